// File: doc/BRIEF.md
# Single-Bit Static Memory with True and Inverted Outputs

This block stores one bit at each of 256 addresses and presents the addressed bit on two outputs at once: one with the polarity of the data input and one inverted. Each output is a value paired with an output-enable. A consumer can use the pair to build an on-chip tri-state driver or feed it into a mux. Because every instance uses the same enable for both outputs, several instances can share one return line in wired-OR fashion, with the select line of each instance picking the active one.

Writes are captured on the rising clock edge. Reads are combinational from the address and the storage array, so a new address gives its bit in the same cycle. A small controller follows the select and write-enable lines through four named states:

- `ST_DESEL`: not selected.
- `ST_READ`: selected and reading.
- `ST_WRITE`: selected and storing.
- `ST_LOCKED`: selected with write enable high, but the write pulse was not preceded by a selected read cycle, so the write is refused.

The controller moves between these states as follows:

- Select high sends the controller to `ST_DESEL` from any state.
- Select low with write enable low sends it to `ST_READ`.
- Select low with write enable high sends it to `ST_WRITE` from `ST_READ` or `ST_WRITE`, and to `ST_LOCKED` from `ST_DESEL` or `ST_LOCKED`.

A monitor counts consecutive storing cycles and raises a flag when the write pulse lasts longer than a parameterised limit.

Top module: `bitram_top`

## Requirements
- R1: The array holds 256 independent one-bit locations, each selected by the full 8-bit address. Every location can be written and read back without disturbing the others.
- R2: While `sel_n` is 1, both `q_oe` and `qn_oe` are 0 and no location changes, whatever `wr_en`, `addr` and `din` do.
- R3: While `sel_n` is 0 and `wr_en` is 0, `q` shows the stored bit of `addr` in the same cycle the address is applied, and both enables are 1.
- R4: `qn` is always the inverse of `q`.
- R5: A location is stored at a rising clock edge only when, in the cycle before that edge, `sel_n` is 0 and `wr_en` is 1 and the controller is in `ST_READ` or `ST_WRITE`. The value stored is `din` at `addr`.
- R6: In a storing cycle, `q` equals `din` and `qn` equals its inverse.
- R7: Within one window of `sel_n` at 0, a read of a location followed by raising `wr_en` stores new data at that same address. The new value is visible on `q` once `wr_en` falls again, without deselecting.
- R8: If `wr_en` is already 1 when `sel_n` falls, nothing is stored. Nothing is stored until `wr_en` has been 0 for at least one selected cycle. During such a refused pulse, `q` shows the stored bit and not `din`.
- R9: While `rst_n` is 0, both output enables and `wr_overrun` are 0. The storage contents are not initialised.
- R10: With `MAX_WP` = 4, `wr_overrun` is 1 in the cycle after the (MAX_WP+1)-th consecutive storing cycle and stays 1 while storing continues. It returns to 0 one cycle after storing stops. A pulse of exactly `MAX_WP` cycles never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the monitor update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of controller, monitor and enables |
| addr | input | 8 | Location address |
| din | input | 1 | Data to store |
| sel_n | input | 1 | Active-low select |
| wr_en | input | 1 | Active-high write enable |
| q | output | 1 | Addressed bit, same polarity as `din` |
| q_oe | output | 1 | Enable for `q` |
| qn | output | 1 | Inverse of `q` |
| qn_oe | output | 1 | Enable for `qn` |
| wr_overrun | output | 1 | Write pulse longer than `MAX_WP` cycles |

## Verification
Two of the block's functions can land in the same cycle: the falling edge of select and a write pulse that is already asserted. The bench raises `wr_en` while the block is deselected and then drops `sel_n` with `wr_en` still high for two cycles. It then judges the outcome in two ways. During the refused pulse, `q` must carry the old stored bit rather than `din`. Afterwards, a plain read of the same address must return the old bit. The read-modify-write sequence is the complement of this case: the read and the store share one select window, and the new value must appear without the block being deselected.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL  = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_LOCKED = 2'd3
    } bitram_state_e;

endpackage

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
    import bitram_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wr_en,
    output bitram_state_e state_q,
    output logic          wr_go
);

    bitram_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and store strobe
    always_comb begin
        state_d = state_q;
        wr_go   = 1'b0;
        unique case (state_q)
            ST_DESEL, ST_LOCKED: begin
                if (sel_n)       state_d = ST_DESEL;
                else if (wr_en)  state_d = ST_LOCKED;
                else             state_d = ST_READ;
            end
            ST_READ, ST_WRITE: begin
                if (sel_n) begin
                    state_d = ST_DESEL;
                end else if (wr_en) begin
                    state_d = ST_WRITE;
                    wr_go   = 1'b1;
                end else begin
                    state_d = ST_READ;
                end
            end
            default: state_d = ST_DESEL;
        endcase
    end

endmodule

// File: rtl/bitram_array.sv
module bitram_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          rd_bit
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= din;
        end
    end

    assign rd_bit = cells[addr];

endmodule

// File: rtl/bitram_pulse_mon.sv
module bitram_pulse_mon #(
    parameter int MAX_WP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    output logic overrun
);

    localparam int CW = $clog2(MAX_WP + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_WP);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= wr_go && (run_cnt == LIMIT);
            if (!wr_go)               run_cnt <= '0;
            else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bitram_top.sv
module bitram_top
    import bitram_pkg::*;
#(
    parameter int AW     = 8,
    parameter int MAX_WP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    input  logic          sel_n,
    input  logic          wr_en,
    output logic          q,
    output logic          q_oe,
    output logic          qn,
    output logic          qn_oe,
    output logic          wr_overrun
);

    bitram_state_e state_q;
    logic          wr_go;
    logic          rd_bit;
    logic          out_bit;
    logic          drive_en;

    bitram_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .wr_en   (wr_en),
        .state_q (state_q),
        .wr_go   (wr_go)
    );

    bitram_array #(.AW(AW)) u_array (
        .clk    (clk),
        .we     (wr_go),
        .addr   (addr),
        .din    (din),
        .rd_bit (rd_bit)
    );

    bitram_pulse_mon #(.MAX_WP(MAX_WP)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .overrun (wr_overrun)
    );

    // Output path: write-through while storing, array bit otherwise
    always_comb begin
        out_bit  = wr_go ? din : rd_bit;
        drive_en = rst_n & ~sel_n;
    end

    assign q     = out_bit;
    assign qn    = ~out_bit;
    assign q_oe  = drive_en;
    assign qn_oe = drive_en;

endmodule

// File: rtl/bitram_checker.sv
module bitram_checker
    import bitram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          din,
    input logic          sel_n,
    input logic          wr_en,
    input logic          q,
    input logic          q_oe,
    input logic          qn,
    input logic          qn_oe,
    input logic          wr_overrun,
    input bitram_state_e state_q
);

    assert_float_when_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!q_oe && !qn_oe));

    assert_drive_when_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> (q_oe && qn_oe));

    assert_inverse_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        qn == ~q);

    // Stored value reappears on the next selected read of the same address
    assert_store_then_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_en && $past(!sel_n && wr_en &&
            (state_q == ST_READ || state_q == ST_WRITE)) && addr == $past(addr))
        |-> q == $past(din));

    assert_no_store_after_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL && !sel_n && wr_en) |=> state_q == ST_LOCKED);

    assert_overrun_only_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_overrun) |-> ($past(state_q) == ST_WRITE && $past(wr_en) && !$past(sel_n)));

endmodule

bind bitram_top bitram_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .din        (din),
    .sel_n      (sel_n),
    .wr_en      (wr_en),
    .q          (q),
    .q_oe       (q_oe),
    .qn         (qn),
    .qn_oe      (qn_oe),
    .wr_overrun (wr_overrun),
    .state_q    (state_q)
);

// File: tb/bitram_top_test.sv
module bitram_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       din = 1'b0;
    logic       sel_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       q, q_oe, qn, qn_oe, wr_overrun;

    int         n_tests = 0;
    int         n_fail = 0;
    logic [255:0] model;

    always #2 clk = ~clk;

    bitram_top #(.AW(8), .MAX_WP(4)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_n(sel_n), .wr_en(wr_en), .q(q), .q_oe(q_oe),
        .qn(qn), .qn_oe(qn_oe), .wr_overrun(wr_overrun)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic pat(input int a);
        logic [7:0] v;
        v = 8'(a);
        return v[0] ^ v[3] ^ v[5] ^ v[7] ^ (v[1] & v[6]);
    endfunction

    // Armed write in its own select window
    task automatic wr_cell(input int a, input logic d);
        @(negedge clk);
        sel_n = 1'b0; wr_en = 1'b0; addr = 8'(a);
        @(negedge clk);
        wr_en = 1'b1; din = d;
        #1;
        chk(q == d && qn == ~d, "R6 write-through", int'(q), int'(d));
        @(negedge clk);
        wr_en = 1'b0; sel_n = 1'b1;
        model[a] = d;
    endtask

    task automatic rd_cell(input int a, input string tag);
        @(negedge clk);
        sel_n = 1'b0; wr_en = 1'b0; addr = 8'(a);
        #1;
        chk(q == model[a], tag, int'(q), int'(model[a]));
        chk(qn == ~q && q_oe && qn_oe, "R4 inverse/enables", int'({qn, q_oe, qn_oe}), int'({~q, 2'b11}));
    endtask

    task automatic t_reset();
        #1;
        chk(!q_oe && !qn_oe, "R9 enables in reset", int'({q_oe, qn_oe}), 0);
        chk(!wr_overrun, "R9 overrun in reset", int'(wr_overrun), 0);
        @(negedge clk);
        rst_n = 1'b1; sel_n = 1'b1;
    endtask

    task automatic t_fill();
        for (int a = 0; a < 256; a++) wr_cell(a, pat(a));
        for (int a = 0; a < 256; a++) rd_cell(a, "R1 fill readback");
        for (int a = 0; a < 256; a += 17) rd_cell(a, "R3 same-cycle read");
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        sel_n = 1'b1; wr_en = 1'b1;
        for (int a = 0; a < 16; a++) begin
            addr = 8'(a); din = ~model[a];
            #1;
            chk(!q_oe && !qn_oe, "R2 floating", int'({q_oe, qn_oe}), 0);
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int a = 0; a < 16; a++) rd_cell(a, "R2 inhibited write");
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    task automatic t_lockout();
        @(negedge clk);
        sel_n = 1'b1; wr_en = 1'b1; addr = 8'd20; din = ~model[20];
        @(negedge clk);
        sel_n = 1'b0;
        #1;
        chk(q == model[20], "R8 no write-through", int'(q), int'(model[20]));
        @(negedge clk);
        #1;
        chk(q == model[20], "R8 still locked", int'(q), int'(model[20]));
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(q == model[20], "R8 unchanged", int'(q), int'(model[20]));
        @(negedge clk);
        sel_n = 1'b1;
        rd_cell(20, "R8 readback");
    endtask

    task automatic t_rmw();
        logic v;
        @(negedge clk);
        sel_n = 1'b0; wr_en = 1'b0; addr = 8'd33;
        #1;
        v = q;
        chk(v == model[33], "R7 read phase", int'(v), int'(model[33]));
        @(negedge clk);
        wr_en = 1'b1; din = ~v;
        #1;
        chk(q == ~v, "R6 rmw write phase", int'(q), int'(~v));
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(q == ~v, "R7 same-window result", int'(q), int'(~v));
        model[33] = ~v;
        @(negedge clk);
        sel_n = 1'b1;
        rd_cell(33, "R5 stored by rmw");
    endtask

    task automatic t_overrun(input int len);
        @(negedge clk);
        sel_n = 1'b0; wr_en = 1'b0; addr = 8'd50;
        @(negedge clk);
        wr_en = 1'b1; din = 1'b1;
        for (int k = 1; k <= len; k++) begin
            #1;
            chk(wr_overrun == (k >= 6), "R10 during pulse", int'(wr_overrun), int'(k >= 6));
            @(negedge clk);
        end
        wr_en = 1'b0;
        #1;
        chk(wr_overrun == (len >= 5), "R10 after last store", int'(wr_overrun), int'(len >= 5));
        @(negedge clk);
        #1;
        chk(!wr_overrun, "R10 cleared", int'(wr_overrun), 0);
        model[50] = 1'b1;
        sel_n = 1'b1;
        rd_cell(50, "R5 long pulse stored");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_inhibit();
        t_lockout();
        t_rmw();
        t_overrun(4);
        t_overrun(7);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule